// File: doc/BRIEF.md
# Push-Button Input Conditioner

This block takes a raw push-button or sensor level that has no timing relationship to the system clock and may bounce. It produces three clock-domain signals from it: a synchronized copy of the level, a debounced level and a single-cycle press event. Every asynchronous line passes through a two-flop synchronizer before any other logic reads it. Only the first flop of each chain can see a setup or hold violation.

A changeover switch exposes two contacts, a "make" contact and a "break" contact. The block combines them in a set/clear hold register. Bouncing on one contact, while the other stays open, cannot move the debounced level. The press-event output is high for exactly one clock cycle when the synchronized level rises. A button that stays held therefore gives one event.

Top module: `btn_cond`

## Requirements
- R1: `lvl_sync` equals the value of `btn_raw` sampled at the rising clock edge two edges earlier. This is a two-flop chain, and no logic reads the first flop.
- R2: `press_pulse` is high for exactly one clock cycle. That cycle is the one in which `lvl_sync` is 1 and `lvl_sync` in the previous cycle was 0.
- R3: While `btn_raw` stays at 1, `press_pulse` does not fire again after that first event. A long stable press after a bounce burst gives exactly one pulse.
- R4: A falling `lvl_sync` (current 0, previous 1) gives no pulse.
- R5: When `cnt_make` is 1 and `cnt_brk` is 0, `lvl_deb` becomes 1. The change appears three rising edges after the contacts were sampled: two synchronizer edges plus one hold-register edge.
- R6: When `cnt_brk` is 1 and `cnt_make` is 0, `lvl_deb` becomes 0, with the same three-edge latency.
- R7: When both contacts are 0, `lvl_deb` keeps its value. So bounce on one contact, while the other stays open, leaves `lvl_deb` unchanged.
- R8: When both contacts are 1, `lvl_deb` keeps its value instead of taking an undefined one.
- R9: A synchronous reset (`rst` high at a rising edge) clears every synchronizer flop, the previous-level flop and the hold register to 0. In the first cycle after reset, `lvl_sync`, `lvl_deb` and `press_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw asynchronous button or sensor level |
| cnt_make | input | 1 | Changeover switch contact that sets the debounced level |
| cnt_brk | input | 1 | Changeover switch contact that clears the debounced level |
| lvl_sync | output | 1 | Two-flop synchronized copy of `btn_raw` |
| lvl_deb | output | 1 | Debounced level from the two-contact hold register |
| press_pulse | output | 1 | One-cycle pulse on a rising synchronized level |

## Verification
`lvl_sync` is due two rising edges after an input change. `press_pulse` follows it combinationally in that same cycle. `lvl_deb` is due one edge later, three edges after its contacts change. The bench drives all inputs at the falling edge and samples all outputs at the next falling edge. It keeps a three-deep history of what it drove, so each output is compared against the input from exactly the right earlier cycle. The hold-register model is stepped once per cycle, using contacts from three cycles back. After a reset the history is cleared, matching the cleared flops, so the blank cycles right after reset are predicted as well.

// File: rtl/btn_cond_pkg.sv
package btn_cond_pkg;

    // Lane order inside the shared synchronizer bank
    localparam int LANE_BTN  = 0;
    localparam int LANE_MAKE = 1;
    localparam int LANE_BRK  = 2;
    localparam int N_LANES   = 3;

    // Contact command seen by the hold register: {make, brk}
    typedef enum logic [1:0] {
        CMD_KEEP = 2'b00,
        CMD_CLR  = 2'b01,
        CMD_SET  = 2'b10,
        CMD_BOTH = 2'b11
    } contact_cmd_e;

    function automatic logic hold_next(input logic cur, input contact_cmd_e cmd);
        case (cmd)
            CMD_SET: hold_next = 1'b1;
            CMD_CLR: hold_next = 1'b0;
            default: hold_next = cur;
        endcase
    endfunction

endpackage

// File: rtl/btn_sync_bank.sv
module btn_sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        bank_d.stg[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            bank_d.stg[i] = bank_q.stg[i-1];
        end
        if (rst) begin
            bank_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    // Only the last stage leaves this module
    assign sync_out = bank_q.stg[LAST];
endmodule

// File: rtl/btn_hold_reg.sv
module btn_hold_reg
    import btn_cond_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic make_s,
    input  logic brk_s,
    output logic level
);
    typedef struct packed {
        logic lvl;
    } hold_t;

    hold_t hold_d, hold_q;
    contact_cmd_e cmd;

    always_comb begin
        cmd = contact_cmd_e'({make_s, brk_s});
        hold_d.lvl = hold_next(hold_q.lvl, cmd);
        if (rst) begin
            hold_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        hold_q <= hold_d;
    end

    assign level = hold_q.lvl;
endmodule

// File: rtl/btn_rise_pulse.sv
module btn_rise_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d.prev = level;
        if (rst) begin
            edge_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        edge_q <= edge_d;
    end

    assign pulse = level & ~edge_q.prev;
endmodule

// File: rtl/btn_cond.sv
module btn_cond
    import btn_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    input  logic cnt_make,
    input  logic cnt_brk,
    output logic lvl_sync,
    output logic lvl_deb,
    output logic press_pulse
);
    logic [N_LANES-1:0] lane_async;
    logic [N_LANES-1:0] lane_sync;

    always_comb begin
        lane_async            = '0;
        lane_async[LANE_BTN]  = btn_raw;
        lane_async[LANE_MAKE] = cnt_make;
        lane_async[LANE_BRK]  = cnt_brk;
    end

    btn_sync_bank #(
        .WIDTH  (N_LANES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (lane_async),
        .sync_out (lane_sync)
    );

    btn_hold_reg u_hold (
        .clk    (clk),
        .rst    (rst),
        .make_s (lane_sync[LANE_MAKE]),
        .brk_s  (lane_sync[LANE_BRK]),
        .level  (lvl_deb)
    );

    btn_rise_pulse u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (lane_sync[LANE_BTN]),
        .pulse (press_pulse)
    );

    assign lvl_sync = lane_sync[LANE_BTN];
endmodule

module btn_cond_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic btn_raw,
    input logic cnt_make,
    input logic cnt_brk,
    input logic lvl_sync,
    input logic lvl_deb,
    input logic press_pulse
);
    // Edges seen since the last reset edge, saturating at 3
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
        press_pulse |=> !press_pulse);

    // R4 and R3: a pulse only on a low-to-high step of the synchronized level
    assert_pulse_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && press_pulse) |-> (lvl_sync && !$past(lvl_sync)));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lvl_sync && !lvl_deb && !press_pulse));

    generate
        if (SYNC_STAGES == 2) begin : g_two_stage
            assert_sync_latency_R1: assert property (@(posedge clk) disable iff (rst)
                (since_rst >= 2'd2) |-> (lvl_sync == $past(btn_raw, 2)));

            assert_deb_set_R5: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd3 && $past(cnt_make, 3) && !$past(cnt_brk, 3)) |-> lvl_deb);

            assert_deb_clr_R6: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd3 && !$past(cnt_make, 3) && $past(cnt_brk, 3)) |-> !lvl_deb);

            // R7 (both open) and R8 (both closed) keep the level
            assert_deb_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd3 && ($past(cnt_make, 3) == $past(cnt_brk, 3)))
                |-> (lvl_deb == $past(lvl_deb)));
        end
    endgenerate
endmodule

bind btn_cond btn_cond_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .btn_raw     (btn_raw),
    .cnt_make    (cnt_make),
    .cnt_brk     (cnt_brk),
    .lvl_sync    (lvl_sync),
    .lvl_deb     (lvl_deb),
    .press_pulse (press_pulse)
);

// File: tb/sim_btn_cond.sv
`timescale 1ns/1ps
module sim_btn_cond;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_raw = 1'b0;
    logic cnt_make = 1'b0;
    logic cnt_brk = 1'b0;
    logic lvl_sync, lvl_deb, press_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // History of driven values: *1 = one falling edge ago, *2 = two, *3 = three
    logic r1, r2, r3, m1, m2, m3, b1, b2, b3;
    logic deb_exp;
    logic obs_pulse;

    always #4 clk = ~clk;   // 125 MHz

    btn_cond u0 (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .cnt_make(cnt_make),
        .cnt_brk(cnt_brk), .lvl_sync(lvl_sync), .lvl_deb(lvl_deb),
        .press_pulse(press_pulse)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: check outputs against history, then drive new inputs
    task automatic step(input logic raw, input logic mk, input logic bk);
        logic ep;
        @(negedge clk);
        case ({m3, b3})
            2'b10: deb_exp = 1'b1;
            2'b01: deb_exp = 1'b0;
            default: ;
        endcase
        ep = r2 & ~r3;
        chk("R1 lvl_sync", lvl_sync, r2);
        if (ep) chk("R2 press_pulse", press_pulse, 1'b1);
        else if (r3 && !r2) chk("R4 press_pulse", press_pulse, 1'b0);
        else chk("R3 press_pulse", press_pulse, 1'b0);
        case ({m3, b3})
            2'b10: chk("R5 lvl_deb", lvl_deb, deb_exp);
            2'b01: chk("R6 lvl_deb", lvl_deb, deb_exp);
            2'b11: chk("R8 lvl_deb", lvl_deb, deb_exp);
            default: chk("R7 lvl_deb", lvl_deb, deb_exp);
        endcase
        obs_pulse = press_pulse;
        r3 = r2; r2 = r1; r1 = raw;
        m3 = m2; m2 = m1; m1 = mk;
        b3 = b2; b2 = b1; b1 = bk;
        btn_raw = raw; cnt_make = mk; cnt_brk = bk;
    endtask

    task automatic do_reset(input logic raw, input logic mk, input logic bk, input int n);
        @(negedge clk);
        rst = 1'b1;
        btn_raw = raw; cnt_make = mk; cnt_brk = bk;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9 lvl_sync", lvl_sync, 1'b0);
            chk("R9 lvl_deb", lvl_deb, 1'b0);
            chk("R9 press_pulse", press_pulse, 1'b0);
        end
        rst = 1'b0;
        r3 = 0; r2 = 0; r1 = raw;
        m3 = 0; m2 = 0; m1 = mk;
        b3 = 0; b2 = 0; b1 = bk;
        deb_exp = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1-watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int npulse;
        // R9: reset with everything active, first cycles after reset stay blank
        do_reset(1'b1, 1'b1, 1'b0, 4);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0);

        // Near-exhaustive sweep: every contact command after every other,
        // from both debounced states, with a random button level
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int k = 0; k < 4; k++) step(1'($urandom % 2), a[1], a[0]);
                for (int k = 0; k < 4; k++) step(1'($urandom % 2), b[1], b[0]);
            end
        end

        // R7: make contact bounces while break stays open, after a clear and after a set
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 24; k++) step(1'b0, 1'($urandom % 2), 1'b0);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 24; k++) step(1'b0, 1'($urandom % 2), 1'b0);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b0);

        // R3: bounce burst ending low, then a long stable press gives one pulse
        for (int k = 0; k < 30; k++) step(1'($urandom % 2), 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        npulse = 0;
        for (int k = 0; k < 200; k++) begin
            step(1'b1, 1'b0, 1'b0);
            if (obs_pulse) npulse++;
        end
        n_cmp++;
        if (npulse != 1) begin
            n_bad++;
            $display("FAIL R3 pulses_during_hold actual=%0d expected=1", npulse);
        end
        // R4: release gives no pulse
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0);

        // R9: reset in mid-run with the button held, then one clean press event
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0);
        do_reset(1'b1, 1'b0, 1'b1, 2);
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule